// File: doc/BRIEF.md
# Recovering-Store Forwarding Unit

When a load has been allowed to fault without trapping, its fault is logged in a status slot: the faulting address, the destination register, and whether that register is integer or float. A later store to the same address can repair the damage. This unit receives such a store and compares the store address with every eligible slot. A slot is eligible when it is valid and its index is below the number of slots implemented. The lowest-indexed slot whose address matches is selected.

On a hit, two things start together. The unit asks the data cache to invalidate and flush the line that holds the address, and keeps that request up until the cache acknowledges it. It also copies the stored register data, one 32-bit word per cycle, into the register the deferred load was meant to fill. Source and destination register numbers both advance by one on each word. If no slot matches, the unit only reports completion.

The register files and the cache are outside the block. The unit reads the source register through a combinational read port and issues one write request per cycle.

Top module: `rsf_fwd_unit`

## Requirements
- R1: After reset, busy, done, wr_en and inv_req are all low.
- R2: A slot takes part in the search only if its slot_valid bit is set and its index is below slot_count; a slot that fails either test never causes a hit, even when its address matches.
- R3: When several eligible slots match the store address, only the one with the lowest index is used; its destination register and file drive the writes.
- R4: On a hit, inv_req rises in the cycle after start, with inv_addr equal to the store address with its low log2(LINE_BYTES) bits cleared. It stays high, with a stable address, through the cycle in which inv_ack is sampled high, and is low in the next cycle.
- R5: st_size encodes the store width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes, 4 is 16 bytes. A hit produces 1, 1, 1, 2 or 4 write cycles respectively. The writes fall in consecutive cycles, and the first comes in the cycle after start.
- R6: wr_data is rd_data zero-extended from bits [7:0] for size code 0 and from bits [15:0] for size code 1; for the other codes it is rd_data unchanged.
- R7: For write k (counting from 0), rd_reg is st_src_reg+k and wr_reg is the slot's destination register+k, both modulo 2^RW.
- R8: wr_fp equals the selected slot's slot_fp bit, and rd_fp equals st_src_fp.
- R9: With no hit, no write or invalidate is issued, busy stays low, and done is high for exactly one cycle: the cycle after start.
- R10: After a hit, busy is high from the cycle after start until both the last write and the acknowledge have happened. done is then high for one cycle, with busy low. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe presenting a store |
| st_addr | input | AW | Store address |
| st_size | input | 3 | Store size code (see R5) |
| st_src_reg | input | RW | First source register of the store |
| st_src_fp | input | 1 | Source register is in the float file |
| slot_valid | input | NSLOT | Valid bit per status slot |
| slot_count | input | CW | Number of implemented slots |
| slot_addr | input | NSLOT*AW | Logged fault address per slot, slot i at bits [i*AW +: AW] |
| slot_dst | input | NSLOT*RW | Destination register per slot, slot i at bits [i*RW +: RW] |
| slot_fp | input | NSLOT | Destination is in the float file, per slot |
| rd_reg | output | RW | Register read port address |
| rd_fp | output | 1 | Register read port selects the float file |
| rd_data | input | 32 | Combinational read data |
| wr_en | output | 1 | Register write request |
| wr_fp | output | 1 | Write targets the float file |
| wr_reg | output | RW | Write register number |
| wr_data | output | 32 | Write data |
| inv_req | output | 1 | Cache line invalidate-and-flush request |
| inv_addr | output | AW | Line-aligned address to invalidate |
| inv_ack | input | 1 | Cache accepts the invalidate |
| busy | output | 1 | Forwarding in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds slot tables in which several slots share the store address. Some of those slots are invalid or sit at or above the implemented count, and some eligible slots match at a higher index. A design that ignored slot_count, or let the highest match win, would write to the wrong register or file. The bench varies the acknowledge delay both below and above the word count. This catches a unit that drops inv_req too early or finishes before the cache has answered. It also covers every size code, and a multiword copy that starts at register 63 so the register numbers wrap; a wrong byte mask, word count or register step shows up as bad write data or a bad register number. A stray start during a copy checks that the unit does not restart.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_WAIT = 2'd2
    } rsf_state_e;

    // Number of word transfers for a size code.
    function automatic logic [2:0] words_for_size(input logic [2:0] sz);
        case (sz)
            3'd0, 3'd1, 3'd2: return 3'd1;
            3'd3:             return 3'd2;
            default:          return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/rsf_slot_match.sv
module rsf_slot_match #(
    parameter int NSLOT = 8,
    parameter int AW    = 32,
    parameter int RW    = 6,
    parameter int CW    = $clog2(NSLOT + 1)
) (
    input  logic [NSLOT-1:0]    slot_valid,
    input  logic [CW-1:0]       slot_count,
    input  logic [NSLOT*AW-1:0] slot_addr,
    input  logic [NSLOT*RW-1:0] slot_dst,
    input  logic [NSLOT-1:0]    slot_fp,
    input  logic [AW-1:0]       key,
    output logic                hit,
    output logic [RW-1:0]       hit_dst,
    output logic                hit_fp
);
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [NSLOT-1:0] elig;
    logic [IW-1:0]    sel;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign elig[g] = slot_valid[g] && (CW'(g) < slot_count)
                      && (slot_addr[g*AW +: AW] == key);
    end

    // Descending walk: the last assignment is the lowest index.
    always_comb begin
        sel = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (elig[i]) sel = IW'(i);
        end
    end

    assign hit     = |elig;
    assign hit_dst = slot_dst[sel*RW +: RW];
    assign hit_fp  = slot_fp[sel];

    // R3: the chosen slot is itself eligible and nothing below it is
    always_comb begin
        if (hit) begin
            lowest_sel_chk: assert (elig[sel] && ((elig & ((NSLOT'(1) << sel) - NSLOT'(1))) == '0));
        end
    end
endmodule

// File: rtl/rsf_data_mask.sv
module rsf_data_mask #(
    parameter int DW = 32
) (
    input  logic [2:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_comb begin
        case (size)
            3'd0:    dout = {{(DW-8){1'b0}},  din[7:0]};
            3'd1:    dout = {{(DW-16){1'b0}}, din[15:0]};
            default: dout = din;
        endcase
    end

    // R6: narrow stores never carry upper bits
    always_comb begin
        if (size == 3'd0) begin
            byte_mask_chk: assert (dout[DW-1:8] == '0);
        end
    end
endmodule

// File: rtl/rsf_fwd_unit.sv
module rsf_fwd_unit #(
    parameter int NSLOT      = 8,
    parameter int AW         = 32,
    parameter int RW         = 6,
    parameter int LINE_BYTES = 32,
    parameter int CW         = $clog2(NSLOT + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [AW-1:0]                st_addr,
    input  logic [2:0]                   st_size,
    input  logic [RW-1:0]                st_src_reg,
    input  logic                         st_src_fp,
    input  logic [NSLOT-1:0]             slot_valid,
    input  logic [CW-1:0]                slot_count,
    input  logic [NSLOT*AW-1:0]          slot_addr,
    input  logic [NSLOT*RW-1:0]          slot_dst,
    input  logic [NSLOT-1:0]             slot_fp,
    output logic [RW-1:0]                rd_reg,
    output logic                         rd_fp,
    input  logic [rsf_pkg::DATA_W-1:0]   rd_data,
    output logic                         wr_en,
    output logic                         wr_fp,
    output logic [RW-1:0]                wr_reg,
    output logic [rsf_pkg::DATA_W-1:0]   wr_data,
    output logic                         inv_req,
    output logic [AW-1:0]                inv_addr,
    input  logic                         inv_ack,
    output logic                         busy,
    output logic                         done
);
    import rsf_pkg::*;

    localparam int LINE_LSB = $clog2(LINE_BYTES);

    typedef struct packed {
        rsf_state_e    state;
        logic [2:0]    left;
        logic [RW-1:0] src;
        logic [RW-1:0] dst;
        logic          src_fp;
        logic          dst_fp;
        logic [2:0]    size;
        logic          inv;
        logic [AW-1:0] line;
        logic          done;
    } regs_t;

    regs_t q, d;

    logic          m_hit;
    logic [RW-1:0] m_dst;
    logic          m_fp;

    rsf_slot_match #(.NSLOT(NSLOT), .AW(AW), .RW(RW), .CW(CW)) match_i (
        .slot_valid (slot_valid),
        .slot_count (slot_count),
        .slot_addr  (slot_addr),
        .slot_dst   (slot_dst),
        .slot_fp    (slot_fp),
        .key        (st_addr),
        .hit        (m_hit),
        .hit_dst    (m_dst),
        .hit_fp     (m_fp)
    );

    rsf_data_mask #(.DW(DATA_W)) mask_i (
        .size (q.size),
        .din  (rd_data),
        .dout (wr_data)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.inv && inv_ack) d.inv = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (m_hit) begin
                        d.state  = ST_COPY;
                        d.left   = words_for_size(st_size);
                        d.src    = st_src_reg;
                        d.dst    = m_dst;
                        d.src_fp = st_src_fp;
                        d.dst_fp = m_fp;
                        d.size   = st_size;
                        d.inv    = 1'b1;
                        d.line   = {st_addr[AW-1:LINE_LSB], {LINE_LSB{1'b0}}};
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            ST_COPY: begin
                d.src  = q.src + RW'(1);
                d.dst  = q.dst + RW'(1);
                d.left = q.left - 3'd1;
                if (q.left == 3'd1) begin
                    if (!d.inv) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!d.inv) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, left: '0, src: '0, dst: '0, src_fp: 1'b0,
                   dst_fp: 1'b0, size: '0, inv: 1'b0, line: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_reg   = q.src;
    assign rd_fp    = q.src_fp;
    assign wr_en    = (q.state == ST_COPY);
    assign wr_reg   = q.dst;
    assign wr_fp    = q.dst_fp;
    assign inv_req  = q.inv;
    assign inv_addr = q.line;
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;

    // R4
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && !inv_ack |=> inv_req && $stable(inv_addr));
    // R4
    inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req && inv_ack |=> !inv_req);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !wr_en && !inv_req);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R7
    reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_reg == $past(wr_reg) + RW'(1)
                               && rd_reg == $past(rd_reg) + RW'(1));
    // R8
    file_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> $stable(wr_fp) && $stable(rd_fp));
    // R9
    miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !m_hit |=> done && !inv_req && !wr_en);
endmodule

// File: tb/rsf_fwd_unit_tb_top.sv
module rsf_fwd_unit_tb_top;
    localparam int NS = 8;
    localparam int AW = 32;
    localparam int RW = 6;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     st_addr = '0;
    logic [2:0]        st_size = '0;
    logic [RW-1:0]     st_src_reg = '0;
    logic              st_src_fp = 1'b0;
    logic [NS-1:0]     slot_valid = '0;
    logic [CW-1:0]     slot_count = '0;
    logic [NS*AW-1:0]  slot_addr;
    logic [NS*RW-1:0]  slot_dst;
    logic [NS-1:0]     slot_fp = '0;
    logic [RW-1:0]     rd_reg;
    logic              rd_fp;
    logic [31:0]       rd_data;
    logic              wr_en, wr_fp, inv_req, busy, done;
    logic [RW-1:0]     wr_reg;
    logic [31:0]       wr_data;
    logic [AW-1:0]     inv_addr;
    logic              inv_ack = 1'b0;

    logic [AW-1:0] b_addr [NS];
    logic [RW-1:0] b_dst  [NS];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rsf_fwd_unit #(.NSLOT(NS), .AW(AW), .RW(RW), .LINE_BYTES(32), .CW(CW)) dut_i (
        .clk, .rst_n, .start, .st_addr, .st_size, .st_src_reg, .st_src_fp,
        .slot_valid, .slot_count, .slot_addr, .slot_dst, .slot_fp,
        .rd_reg, .rd_fp, .rd_data, .wr_en, .wr_fp, .wr_reg, .wr_data,
        .inv_req, .inv_addr, .inv_ack, .busy, .done
    );

    function automatic logic [31:0] regval(input logic fp, input logic [RW-1:0] r);
        return (32'h9E3779B9 * ({26'd0, r} + 32'd1)) ^ (fp ? 32'hFFFF0000 : 32'h0000FFFF);
    endfunction

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            slot_addr[i*AW +: AW] = b_addr[i];
            slot_dst[i*RW +: RW]  = b_dst[i];
        end
    end
    assign rd_data = regval(rd_fp, rd_reg);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int find_slot(input logic [AW-1:0] a);
        for (int i = 0; i < NS; i++)
            if (slot_valid[i] && i < int'(slot_count) && b_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int nwords(input logic [2:0] sz);
        return (sz <= 3'd2) ? 1 : (sz == 3'd3) ? 2 : 4;
    endfunction

    function automatic logic [31:0] masked(input logic [2:0] sz, input logic [31:0] v);
        if (sz == 3'd0) return v & 32'hFF;
        if (sz == 3'd1) return v & 32'hFFFF;
        return v;
    endfunction

    // One store; ackd = cycle (1-based) in which the cache acknowledges.
    task automatic run_op(input logic [AW-1:0] a, input logic [2:0] sz,
                          input logic [RW-1:0] src, input logic sfp,
                          input int ackd, input bit poke);
        int idx, nw, fin;
        logic [RW-1:0] dst0;
        logic dfp;
        @(negedge clk);
        idx = find_slot(a);
        nw  = nwords(sz);
        dst0 = (idx >= 0) ? b_dst[idx] : '0;
        dfp  = (idx >= 0) ? slot_fp[idx] : 1'b0;
        st_addr = a; st_size = sz; st_src_reg = src; st_src_fp = sfp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (idx < 0) begin
            chk(done == 1'b1, "R9", "done after miss", 64'(done), 64'd1);
            chk(!wr_en && !inv_req && !busy, "R9", "quiet on miss",
                {61'd0, wr_en, inv_req, busy}, 64'd0);
            @(negedge clk);
            chk(!done && !busy, "R9", "single done", {62'd0, done, busy}, 64'd0);
        end else begin
            fin = (nw > ackd) ? nw : ackd;
            for (int k = 1; k <= fin + 2; k++) begin
                inv_ack = (k == ackd);
                if (poke && k == 1) begin
                    start = 1'b1; st_addr = a ^ 32'h40;
                end
                chk(wr_en == (k <= nw), "R5", "wr_en", 64'(wr_en), 64'(k <= nw));
                if (wr_en && k <= nw) begin
                    chk(wr_reg == RW'(dst0 + RW'(k - 1)), "R7", "wr_reg",
                        64'(wr_reg), 64'(RW'(dst0 + RW'(k - 1))));
                    chk(wr_fp == dfp && rd_fp == sfp, "R8", "files",
                        {62'd0, wr_fp, rd_fp}, {62'd0, dfp, sfp});
                    chk(wr_data == masked(sz, regval(sfp, RW'(src + RW'(k - 1)))),
                        "R6", "wr_data", 64'(wr_data),
                        64'(masked(sz, regval(sfp, RW'(src + RW'(k - 1))))));
                end
                chk(inv_req == (k <= ackd), "R4", "inv_req", 64'(inv_req), 64'(k <= ackd));
                if (inv_req)
                    chk(inv_addr == (a & ~32'h1F), "R4", "inv_addr",
                        64'(inv_addr), 64'(a & ~32'h1F));
                chk(busy == (k <= fin), "R10", "busy", 64'(busy), 64'(k <= fin));
                chk(done == (k == fin + 1), "R10", "done", 64'(done), 64'(k == fin + 1));
                @(negedge clk);
                start = 1'b0;
            end
            inv_ack = 1'b0;
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NS; i++) begin
            b_addr[i] = 32'h0BAD_0000 + 32'(i * 4);
            b_dst[i]  = RW'(i * 5);
        end
        slot_valid = '0; slot_fp = '0; slot_count = CW'(NS);
    endtask

    initial begin
        logic [AW-1:0] pool [4];
        pool[0] = 32'h1000_0004; pool[1] = 32'h1000_0024;
        pool[2] = 32'h2000_007C; pool[3] = 32'h1000_001F;
        void'($urandom(32'd2024));
        clear_slots();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !wr_en && !inv_req, "R1", "reset outputs",
            {60'd0, busy, done, wr_en, inv_req}, 64'd0);
        rst_n = 1'b1;

        // R9: nothing implemented
        slot_count = '0; slot_valid = '1; b_addr[0] = pool[0];
        run_op(pool[0], 3'd2, 6'd3, 1'b0, 1, 1'b0);

        // R2: matches only at an invalid slot and at an index >= count
        clear_slots();
        b_addr[1] = pool[1]; b_addr[5] = pool[1];
        slot_valid = 8'b0010_0000; slot_count = 4'd5;
        run_op(pool[1], 3'd2, 6'd7, 1'b0, 1, 1'b0);
        slot_count = 4'd6;
        run_op(pool[1], 3'd2, 6'd7, 1'b1, 2, 1'b0);

        // R3: two eligible matches, lowest wins; R8 float destination
        clear_slots();
        b_addr[2] = pool[2]; b_dst[2] = 6'd20; slot_fp[2] = 1'b1;
        b_addr[6] = pool[2]; b_dst[6] = 6'd40;
        slot_valid = 8'b0100_0100;
        run_op(pool[2], 3'd3, 6'd10, 1'b0, 1, 1'b0);

        // R5/R6: every size code, late ack, R7 wrap from register 63
        for (int s = 0; s <= 4; s++) begin
            run_op(pool[2], 3'(s), 6'd62, 1'(s[0]), 4, 1'b0);
        end
        b_dst[2] = 6'd63;
        run_op(pool[2], 3'd4, 6'd63, 1'b1, 1, 1'b0);
        // R10: start during busy is ignored
        run_op(pool[2], 3'd4, 6'd5, 1'b0, 2, 1'b1);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NS; i++) begin
                b_addr[i] = pool[$urandom_range(0, 3)];
                b_dst[i]  = RW'($urandom);
            end
            slot_valid = NS'($urandom);
            slot_fp    = NS'($urandom);
            slot_count = CW'($urandom_range(0, NS));
            run_op(pool[$urandom_range(0, 3)], 3'($urandom_range(0, 4)),
                   RW'($urandom), 1'($urandom), $urandom_range(1, 5), 1'($urandom_range(0, 9) == 0));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule